// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames. Software or a bus front end places characters in a holding store. The store is either a 16-entry first-in first-out queue or a single register, chosen at run time. A frame engine takes the oldest character and shifts it onto the line, least significant bit first. Timing comes from an enable pulse, `tick16`, that arrives sixteen times per bit period. A divisor stage outside this block produces that pulse.

The frame layout is chosen at run time: 5 to 8 data bits, optional even or odd parity, and 1, 1.5 or 2 stop bits. These settings are captured when a frame begins, so changing them during a frame does not disturb that frame. A break control forces the line low. A loopback control keeps the external pin quiet and routes the frame to an internal tap. A clear-to-send input gates the start of each new frame. Status outputs report whether the holding store and the shifter are empty.

Top module: `uart_ser_tx`

## Requirements
- R1: After reset, `txd` and `loop_tap` are high (idle), and `holding_empty`, `shift_empty` and `tx_empty` are 1, while `holding_full` is 0 with `fifo_mode` = 1.
- R2: A frame is one low start bit followed by the data bits, least significant first. Every bit, start bit included, lasts exactly 16 `tick16` pulses. A frame begins only on a cycle in which `tick16` is high, and the line changes only on such pulses unless `break_en` changes.
- R3: `char_len` selects the number of data bits: 0 → 5, 1 → 6, 2 → 7, 3 → 8. Bits above the selected length are not sent.
- R4: With `parity_en` = 1, one parity bit follows the data. With `parity_odd` = 0 it makes the count of ones in the data and parity bits even; with `parity_odd` = 1 it makes that count odd. With `parity_en` = 0 no parity bit is sent.
- R5: The high stop level lasts 16 ticks when `stop_two` = 0. With `stop_two` = 1 it lasts 32 ticks, except when `char_len` = 0 (5 bits), where it lasts 24 ticks.
- R6: While `break_en` is 1, `loop_tap` is low and `txd` is low (unless looped back). The frame engine keeps running underneath.
- R7: A new frame starts only when `cts_ok` is 1 on the starting tick. Dropping `cts_ok` does not cut off a frame already in progress.
- R8: With `fifo_mode` = 1 the holding store accepts 16 characters; with `fifo_mode` = 0 it accepts one. `holding_full` reports the limit, and a write while full is dropped.
- R9: `holding_empty` is 1 when no character is held, and `shift_empty` is 1 when no frame is in progress. `tx_empty` is 1 only when both are 1.
- R10: With `loop_en` = 1, `txd` stays high and `loop_tap` carries the frame. With `loop_en` = 0, `txd` and `loop_tap` carry the same level.
- R11: The character length, parity and stop settings are captured at frame start. Changing them during a frame affects only later frames.
- R12: When another character is waiting and `cts_ok` is 1, the next start bit follows the last stop tick with no idle tick between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversample enable, 16 per bit |
| wr_en | input | 1 | Write a character into the holding store |
| wr_data | input | 8 | Character to write |
| fifo_mode | input | 1 | 1: 16-entry queue, 0: single holding register |
| char_len | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_two | input | 1 | Long stop (2 bits, or 1.5 bits for 5-bit characters) |
| break_en | input | 1 | Force the line low |
| loop_en | input | 1 | Internal loopback, external pin held idle |
| cts_ok | input | 1 | Permission to start a frame |
| txd | output | 1 | Serial output pin |
| loop_tap | output | 1 | Internal copy of the line for loopback |
| holding_full | output | 1 | Holding store at capacity |
| holding_empty | output | 1 | Holding store empty |
| shift_empty | output | 1 | No frame in progress |
| tx_empty | output | 1 | Holding store and shifter both empty |

## Verification
The hardest cases to reach from the ports are a full queue and the boundary between frames. A full queue is built by holding `cts_ok` low while 17 characters are written. Releasing `cts_ok` then drains the queue as one back-to-back burst, so every frame boundary hits the case where the last stop tick and the next start coincide. Break, loopback and configuration changes are applied in the middle of frames. The reference model builds each frame as a list of per-tick line levels and compares the outputs on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       stop_two;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_tx_hold_fifo.sv
module uart_tx_hold_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     cap;
  logic              push;

  assign cap   = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign full  = (cnt_q >= cap);
  assign empty = (cnt_q == '0);
  assign push  = push_req && !full;
  assign head  = mem_q[rd_q];
  assign count = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TPB    = 16,
  localparam int CNT_W = $clog2(2 * TPB),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              can_start,
  input  logic [DATA_W-1:0] ld_data,
  input  frame_cfg_t        cfg_in,
  output logic              pop,
  output logic              line,
  output logic              busy
);
  localparam logic [CNT_W:0] STOP_ONE  = (CNT_W + 1)'(TPB);
  localparam logic [CNT_W:0] STOP_HALF = (CNT_W + 1)'(TPB + TPB / 2);
  localparam logic [CNT_W:0] STOP_TWO  = (CNT_W + 1)'(2 * TPB);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  frame_cfg_t        cfg_q, cfg_d;

  logic              bit_end, stop_end, start_now, ld_par;
  logic [BIT_W-1:0]  last_idx;
  logic [CNT_W:0]    stop_len;

  assign bit_end  = (cnt_q == CNT_W'(TPB - 1));
  assign last_idx = BIT_W'(cfg_q.len_code) + BIT_W'(DATA_W - 4);

  always_comb begin
    if (!cfg_q.stop_two)             stop_len = STOP_ONE;
    else if (cfg_q.len_code == 2'd0) stop_len = STOP_HALF;
    else                             stop_len = STOP_TWO;
  end

  assign stop_end  = ({1'b0, cnt_q} == stop_len - 1'b1);
  assign start_now = tick && can_start &&
                     ((state_q == ST_IDLE) || ((state_q == ST_STOP) && stop_end));

  // parity over the selected data bits of the character being loaded
  always_comb begin
    ld_par = cfg_in.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i <= int'(cfg_in.len_code) + DATA_W - 4) ld_par = ld_par ^ ld_data[i];
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    pop     = 1'b0;
    if (tick) begin
      cnt_d = cnt_q + 1'b1;
      case (state_q)
        ST_START: if (bit_end) begin
          state_d = ST_DATA;
          cnt_d   = '0;
          bit_d   = '0;
        end
        ST_DATA: if (bit_end) begin
          cnt_d = '0;
          sh_d  = sh_q >> 1;
          bit_d = bit_q + 1'b1;
          if (bit_q == last_idx) state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_end) begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end
        ST_STOP: if (stop_end) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
        default: cnt_d = '0;
      endcase
      if (start_now) begin
        state_d = ST_START;
        cnt_d   = '0;
        sh_d    = ld_data;
        par_d   = ld_par;
        cfg_d   = cfg_in;
        pop     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/uart_ser_tx.sv
module uart_ser_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HOLD_DEPTH = 16,
  parameter int TPB        = 16,
  localparam int HCW       = $clog2(HOLD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_mode,
  input  logic [1:0]        char_len,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              stop_two,
  input  logic              break_en,
  input  logic              loop_en,
  input  logic              cts_ok,
  output logic              txd,
  output logic              loop_tap,
  output logic              holding_full,
  output logic              holding_empty,
  output logic              shift_empty,
  output logic              tx_empty
);
  logic              rst_s_n;
  logic              pop, busy, line_raw, line_b, h_empty;
  logic [DATA_W-1:0] head;
  logic [HCW-1:0]    fifo_cnt;
  frame_cfg_t        cfg_now;

  uart_tx_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  uart_tx_hold_fifo #(.DATA_W(DATA_W), .DEPTH(HOLD_DEPTH)) hold_i (
    .clk(clk), .rst_n(rst_s_n), .fifo_mode(fifo_mode),
    .push_req(wr_en), .push_data(wr_data), .pop(pop),
    .head(head), .empty(h_empty), .full(holding_full), .count(fifo_cnt)
  );

  assign cfg_now = '{len_code: char_len, par_en: parity_en,
                     par_odd: parity_odd, stop_two: stop_two};

  uart_tx_framer #(.DATA_W(DATA_W), .TPB(TPB)) framer_i (
    .clk(clk), .rst_n(rst_s_n), .tick(tick16),
    .can_start(!h_empty && cts_ok), .ld_data(head), .cfg_in(cfg_now),
    .pop(pop), .line(line_raw), .busy(busy)
  );

  assign line_b        = break_en ? 1'b0 : line_raw;
  assign loop_tap      = line_b;
  assign txd           = loop_en ? 1'b1 : line_b;
  assign holding_empty = h_empty;
  assign shift_empty   = !busy;
  assign tx_empty      = h_empty && !busy;
endmodule

// File: rtl/uart_ser_tx_chk.sv
module uart_ser_tx_chk #(
  parameter int DEPTH = 16,
  localparam int HCW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick16,
  input logic           cts_ok,
  input logic           break_en,
  input logic           loop_en,
  input logic           txd,
  input logic           loop_tap,
  input logic           holding_empty,
  input logic           shift_empty,
  input logic           tx_empty,
  input logic [HCW-1:0] fifo_count
);
  a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(loop_tap) && $stable(break_en)) |-> $past(tick16));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shift_empty) && !break_en) |-> !loop_tap);

  a_r7_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> ($past(cts_ok) && $past(tick16)));

  a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    break_en |-> !loop_tap);

  a_r10_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> txd);

  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= HCW'(DEPTH));

  a_r9_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (holding_empty && shift_empty));
endmodule

bind uart_ser_tx uart_ser_tx_chk #(.DEPTH(HOLD_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .cts_ok(cts_ok),
  .break_en(break_en), .loop_en(loop_en), .txd(txd), .loop_tap(loop_tap),
  .holding_empty(holding_empty), .shift_empty(shift_empty),
  .tx_empty(tx_empty), .fifo_count(fifo_cnt)
);

// File: tb/uart_ser_tx_tb.sv
module uart_ser_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fifo_mode = 1'b1;
  logic [1:0] char_len = 2'd3;
  logic       parity_en = 1'b0, parity_odd = 1'b0, stop_two = 1'b0;
  logic       break_en = 1'b0, loop_en = 1'b0, cts_ok = 1'b1;
  logic       txd, loop_tap, holding_full, holding_empty, shift_empty, tx_empty;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  uart_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .char_len(char_len), .parity_en(parity_en),
    .parity_odd(parity_odd), .stop_two(stop_two), .break_en(break_en),
    .loop_en(loop_en), .cts_ok(cts_ok), .txd(txd), .loop_tap(loop_tap),
    .holding_full(holding_full), .holding_empty(holding_empty),
    .shift_empty(shift_empty), .tx_empty(tx_empty)
  );

  // tick every third cycle
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 0);
  end

  // ---------------- reference model ----------------
  logic [7:0] hq[$];
  bit         fq[$];
  int         since_rel = 0;

  function automatic void build_frame(logic [7:0] d);
    int n;
    int ones;
    bit p;
    n = int'(char_len) + 5;
    ones = 0;
    fq.delete();
    repeat (16) fq.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      ones += int'(d[i]);
      repeat (16) fq.push_back(d[i]);
    end
    if (parity_en) begin
      p = ((ones % 2) == 1) ^ parity_odd;
      repeat (16) fq.push_back(p);
    end
    if (!stop_two) repeat (16) fq.push_back(1'b1);
    else if (char_len == 2'd0) repeat (24) fq.push_back(1'b1);
    else repeat (32) fq.push_back(1'b1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq.delete();
      fq.delete();
      since_rel = 0;
    end else begin
      since_rel = since_rel + 1;
      if (since_rel >= 3) begin
        bit acc;
        int cap;
        cap = fifo_mode ? 16 : 1;
        acc = wr_en && (hq.size() < cap);
        if (tick16) begin
          if (fq.size() > 0) void'(fq.pop_front());
          if (fq.size() == 0 && hq.size() > 0 && cts_ok) build_frame(hq.pop_front());
        end
        if (acc) hq.push_back(wr_data);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, after the falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n && since_rel >= 3) begin
      bit lv;
      bit lb;
      int cap;
      cap = fifo_mode ? 16 : 1;
      lv = (fq.size() > 0) ? fq[0] : 1'b1;
      lb = break_en ? 1'b0 : lv;
      chk(cur_req, "loop_tap", int'(loop_tap), int'(lb));
      chk(cur_req, "txd", int'(txd), int'(loop_en ? 1'b1 : lb));
      chk(cur_req, "holding_full", int'(holding_full), int'(hq.size() >= cap));
      chk(cur_req, "holding_empty", int'(holding_empty), int'(hq.size() == 0));
      chk(cur_req, "shift_empty", int'(shift_empty), int'(fq.size() == 0));
      chk(cur_req, "tx_empty", int'(tx_empty), int'(hq.size() == 0 && fq.size() == 0));
    end
  end

  // ---------------- stimulus ----------------
  task automatic write_byte(logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while ((hq.size() != 0 || fq.size() != 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(logic [1:0] l, logic pe, logic po, logic st);
    @(negedge clk);
    char_len = l;
    parity_en = pe;
    parity_odd = po;
    stop_two = st;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    cur_req = "R1";
    chk("R1", "reset txd", int'(txd), 1);
    chk("R1", "reset holding_empty", int'(holding_empty), 1);
    chk("R1", "reset tx_empty", int'(tx_empty), 1);
    chk("R1", "reset holding_full", int'(holding_full), 0);

    cur_req = "R2";
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    write_byte(8'hA5);
    wait_idle();

    cur_req = "R3";
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0); write_byte(8'hF3); wait_idle();
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0); write_byte(8'h6A); wait_idle();
    set_cfg(2'd2, 1'b0, 1'b0, 1'b0); write_byte(8'hC9); wait_idle();

    cur_req = "R4";
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0); write_byte(8'h37); wait_idle();
    set_cfg(2'd2, 1'b1, 1'b1, 1'b0); write_byte(8'h55); wait_idle();
    set_cfg(2'd0, 1'b1, 1'b1, 1'b0); write_byte(8'h00); wait_idle();

    cur_req = "R5";
    set_cfg(2'd0, 1'b0, 1'b0, 1'b1); write_byte(8'h1E); wait_idle();
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1); write_byte(8'h81); wait_idle();

    cur_req = "R6";
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    write_byte(8'hFF);
    repeat (60) @(negedge clk);
    break_en = 1'b1;
    repeat (5) @(negedge clk);
    #2 chk("R6", "break line", int'(txd), 0);
    repeat (80) @(negedge clk);
    break_en = 1'b0;
    wait_idle();

    cur_req = "R7";
    cts_ok = 1'b0;
    write_byte(8'h3C);
    repeat (200) @(negedge clk);
    #2 chk("R7", "inhibited shift_empty", int'(shift_empty), 1);
    chk("R7", "inhibited holding_empty", int'(holding_empty), 0);
    @(negedge clk) cts_ok = 1'b1;
    repeat (100) @(negedge clk);
    cts_ok = 1'b0;
    repeat (20) @(negedge clk);
    #2 chk("R7", "frame continues", int'(shift_empty), 0);
    wait_idle();
    cts_ok = 1'b1;

    cur_req = "R8";
    cts_ok = 1'b0;
    fifo_mode = 1'b1;
    for (int i = 0; i < 16; i++) write_byte(8'(i * 17 + 3));
    #2 chk("R8", "full at 16", int'(holding_full), 1);
    write_byte(8'hEE);
    cur_req = "R12";
    @(negedge clk) cts_ok = 1'b1;
    wait_idle();
    cur_req = "R8";
    cts_ok = 1'b0;
    fifo_mode = 1'b0;
    write_byte(8'h42);
    #2 chk("R8", "single full", int'(holding_full), 1);
    write_byte(8'h99);
    @(negedge clk) cts_ok = 1'b1;
    wait_idle();
    fifo_mode = 1'b1;

    cur_req = "R9";
    write_byte(8'h5A);
    write_byte(8'hA5);
    repeat (10) @(negedge clk);
    #2 chk("R9", "tx_empty busy", int'(tx_empty), 0);
    wait_idle();
    #2 chk("R9", "tx_empty done", int'(tx_empty), 1);

    cur_req = "R10";
    write_byte(8'h0F);
    loop_en = 1'b1;
    repeat (30) @(negedge clk);
    #2 chk("R10", "txd quiet", int'(txd), 1);
    wait_idle();
    loop_en = 1'b0;

    cur_req = "R11";
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1);
    write_byte(8'hB7);
    repeat (60) @(negedge clk);
    set_cfg(2'd0, 1'b0, 1'b1, 1'b0);
    wait_idle();

    cur_req = "R12";
    set_cfg(2'd1, 1'b1, 1'b1, 1'b1);
    write_byte(8'h11); write_byte(8'h22); write_byte(8'h33);
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule